// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block connects an internal single-word request port to an external asynchronous static RAM of 128K bytes. The RAM has two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and a shared 8-bit data bus. The bus is brought out as three signals: data out, data in and a drive enable. The controller turns each accepted request into a sequence of strobe patterns on the RAM pins. It counts clock cycles so that the RAM's minimum access, pulse-width, setup and recovery intervals are met at any clock period.

Requests arrive on a valid/ready handshake that carries an address, a write flag and write data. A read selects the RAM with the output enable low. When the access time has passed, the controller registers the data bus and returns it with a single-cycle valid pulse. A write first selects the RAM with the output enable high. It then drives the data and pulls the write strobe low for the minimum pulse. It raises the strobe while the data is still driven, so the RAM stores the word on that rising edge, and only then releases the bus and the selects. All timing minimums are parameters in picoseconds. The cycle counts are derived from them by rounding up against the clock period.

Top module: `sram_ctl`

## Requirements
- R1: A read returns the byte held at the requested address on `rsp_rdata`, together with `rsp_valid` high for exactly one cycle.
- R2: `ram_we_n` is low only while `ram_cs1_n` is low, `ram_cs2` is high and `ram_oe_n` is high.
- R3: `ram_addr` does not change while the RAM is selected (`ram_cs1_n` low).
- R4: `ram_we_n` stays low for at least ceil(T_WP/CLK) cycles. It also stays low long enough that the address has been stable for T_AW and the data has been driven for T_DS before the strobe rises.
- R5: The data bus is driven (`ram_dq_oe` high) only while `ram_oe_n` is high, and it is driven from the cycle in which the write strobe falls.
- R6: Write data stays constant while the strobe is low, and it is still driven in the cycle in which the strobe rises.
- R7: The read data is sampled after the RAM has been selected with the output enable low for at least T_RC, T_AA and T_OE. At the default parameters (4 ns clock, 55 ns minimums), `rsp_valid` is high in the 16th cycle counted from the accepting edge.
- R8: `req_ready` is high only when the controller is idle. It is low during every cycle in which the RAM is selected, so no request is taken mid-access.
- R9: After reset, `ram_cs1_n`=1, `ram_cs2`=0, `ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R10: Both selects are active for at least one cycle before the write strobe falls, so the RAM outputs never turn on during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Single-cycle read data valid |
| rsp_rdata | output | 8 | Read data |
| ram_addr | output | 17 | RAM address |
| ram_cs1_n | output | 1 | RAM select, active low |
| ram_cs2 | output | 1 | RAM select, active high |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_out` |
| ram_dq_in | input | 8 | Data from the RAM |

## Verification
Some faults cut the timing short, for example a counter reloaded with too small a value or a state skipped. The RAM model at the pins catches these in the same access: a strobe pulse too short, data set up too late, or read data sampled before the access time, which shows as a garbage byte. An address or data register that shifts while the RAM is selected breaks stability at the next clock edge. A write that never reaches the array stays hidden until a later read of that address returns the old byte. For that reason the random traffic reuses a small pool of addresses. A state machine that loses its way shows first in `req_ready` or in the read latency.

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int CLK_PS  = 4000,
  parameter int T_RC_PS = 55000,
  parameter int T_AA_PS = 55000,
  parameter int T_OE_PS = 30000,
  parameter int T_WC_PS = 55000,
  parameter int T_WP_PS = 45000,
  parameter int T_AS_PS = 0,
  parameter int T_AW_PS = 50000,
  parameter int T_DS_PS = 25000,
  parameter int T_WR_PS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs1_n,
  output logic          ram_cs2,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  function automatic int cdiv(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = imax(1, imax(cdiv(T_RC_PS), imax(cdiv(T_AA_PS), cdiv(T_OE_PS))));
  localparam int SU_CYC = imax(1, cdiv(T_AS_PS));
  localparam int HD_CYC = imax(1, cdiv(T_WR_PS));
  localparam int WP_CYC = imax(1, imax(imax(cdiv(T_WP_PS), cdiv(T_DS_PS)),
                                       imax(cdiv(T_AW_PS) - SU_CYC,
                                            cdiv(T_WC_PS) - SU_CYC - HD_CYC)));
  localparam int CW     = $clog2(imax(RD_CYC, imax(WP_CYC, imax(SU_CYC, HD_CYC))) + 1);

  typedef enum logic [2:0] {IDLE, RD_ACCESS, RD_CAPTURE, WR_SETUP, WR_PULSE, WR_RECOVER} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wdata_q;
  wire           cnt_done = (cnt == '0);

  assign req_ready = (st == IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      wdata_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      ram_addr   <= '0;
      ram_cs1_n  <= 1'b1;
      ram_cs2    <= 1'b0;
      ram_we_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      ram_dq_out <= '0;
      ram_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          ram_addr  <= req_addr;
          wdata_q   <= req_wdata;
          ram_cs1_n <= 1'b0;
          ram_cs2   <= 1'b1;
          if (req_write) begin
            st  <= WR_SETUP;
            cnt <= CW'(SU_CYC - 1);
          end else begin
            ram_oe_n <= 1'b0;
            st       <= RD_ACCESS;
            cnt      <= CW'(RD_CYC - 1);
          end
        end
        RD_ACCESS: begin
          cnt <= cnt - 1'b1;
          if (cnt_done) st <= RD_CAPTURE;
        end
        RD_CAPTURE: begin
          rsp_rdata <= ram_dq_in;
          rsp_valid <= 1'b1;
          ram_oe_n  <= 1'b1;
          ram_cs1_n <= 1'b1;
          ram_cs2   <= 1'b0;
          st        <= IDLE;
        end
        WR_SETUP: begin
          cnt <= cnt - 1'b1;
          if (cnt_done) begin
            ram_we_n   <= 1'b0;
            ram_dq_out <= wdata_q;
            ram_dq_oe  <= 1'b1;
            cnt        <= CW'(WP_CYC - 1);
            st         <= WR_PULSE;
          end
        end
        WR_PULSE: begin
          cnt <= cnt - 1'b1;
          if (cnt_done) begin
            ram_we_n <= 1'b1;
            cnt      <= CW'(HD_CYC - 1);
            st       <= WR_RECOVER;
          end
        end
        WR_RECOVER: begin
          cnt <= cnt - 1'b1;
          if (cnt_done) begin
            ram_dq_oe <= 1'b0;
            ram_cs1_n <= 1'b1;
            ram_cs2   <= 1'b0;
            st        <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int CLK_PS  = 4000,
  parameter int T_WP_PS = 45000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] ram_addr,
  input logic          ram_cs1_n,
  input logic          ram_cs2,
  input logic          ram_we_n,
  input logic          ram_oe_n,
  input logic [DW-1:0] ram_dq_out,
  input logic          ram_dq_oe
);
  localparam int WP_MIN = (T_WP_PS + CLK_PS - 1) / CLK_PS;

  logic [15:0] wlow;
  always_ff @(posedge clk) begin
    if (!rst_n)         wlow <= '0;
    else if (!ram_we_n) wlow <= wlow + 1'b1;
    else                wlow <= '0;
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r2_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_cs1_n && ram_cs2 && ram_oe_n));
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs1_n && $past(!ram_cs1_n)) |-> $stable(ram_addr));
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (wlow >= 16'(WP_MIN)));
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n);
  a_r5_drive_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> ram_dq_oe);
  a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_dq_out));
  a_r6_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (ram_dq_oe && $stable(ram_dq_out)));
  a_r8_busy_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs1_n |-> !req_ready);
  a_r10_select_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> $past(!ram_cs1_n && ram_cs2));
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW), .CLK_PS(CLK_PS), .T_WP_PS(T_WP_PS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ram_addr(ram_addr), .ram_cs1_n(ram_cs1_n), .ram_cs2(ram_cs2), .ram_we_n(ram_we_n),
  .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe));

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] ram_addr;
  logic        ram_cs1_n, ram_cs2, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [7:0]  ram_dq_out;
  logic [7:0]  ram_dq_in = 8'hEE;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_ctl dut (.*);

  function automatic logic [7:0] init_val(input logic [16:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // RAM model at the pins
  logic [7:0] mem [int];
  realtime t_ctl = 0, t_addr = 0, t_data = 0, t_wstart = 0, t_sel = 0;
  bit wr_act = 0;
  wire sel = !ram_cs1_n && ram_cs2;

  always @(ram_cs1_n or ram_cs2 or ram_oe_n or ram_we_n or ram_addr) t_ctl = $realtime;
  always @(ram_addr) t_addr = $realtime;
  always @(ram_dq_out or ram_dq_oe) t_data = $realtime;
  always @(ram_cs1_n or ram_cs2) if (sel) t_sel = $realtime;

  always @(ram_we_n or ram_cs1_n or ram_cs2) begin
    if (!wr_act && sel && !ram_we_n) begin
      wr_act = 1;
      t_wstart = $realtime;
      check(t_sel < $realtime, "R10 select before strobe", 0, 1);
    end else if (wr_act && !(sel && !ram_we_n)) begin
      wr_act = 0;
      check($realtime - t_wstart >= 45.0, "R4 pulse width", int'($realtime - t_wstart), 45);
      check($realtime - t_addr >= 50.0, "R4 address to strobe rise", int'($realtime - t_addr), 50);
      check(ram_dq_oe && ($realtime - t_data >= 25.0), "R4 data setup", int'($realtime - t_data), 25);
      check(ram_oe_n, "R5 output enable high in write", ram_oe_n, 1);
      mem[int'(ram_addr)] = ram_dq_out;
    end
  end

  always @(negedge clk) begin
    if (ram_dq_oe && !ram_oe_n) check(0, "R5 bus contention", 1, 0);
    if (sel && ram_we_n && !ram_oe_n && ($realtime - t_ctl >= 55.0))
      ram_dq_in <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : init_val(ram_addr);
    else
      ram_dq_in <= 8'hEE;
  end

  // reference
  logic [7:0] refm [int];
  localparam int RD_LAT = (55000 + 3999) / 4000 + 2;

  task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R8 ready low after accept", req_ready, 0);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    issue(1, a, d);
    refm[int'(a)] = d;
    while (!req_ready) @(negedge clk);
    check(!ram_dq_oe && ram_cs1_n, "R5 bus released after write", ram_dq_oe, 0);
  endtask

  task automatic do_read(input logic [16:0] a);
    int n;
    logic [7:0] e;
    issue(0, a, 8'h00);
    n = 1;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    e = refm.exists(int'(a)) ? refm[int'(a)] : init_val(a);
    check(n == RD_LAT, "R7 read latency", n, RD_LAT);
    check(rsp_rdata == e, "R1 read data", rsp_rdata, e);
    @(negedge clk);
    check(!rsp_valid, "R1 valid is one cycle", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ram_cs1_n && !ram_cs2 && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid && req_ready,
          "R9 reset state", {ram_cs1_n, ram_cs2, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid, req_ready},
          7'b1011001);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    do_read(17'h00000);
    do_write(17'h00000, 8'h3C);
    do_write(17'h1FFFF, 8'hC3);
    do_read(17'h1FFFF);
    do_read(17'h00000);
    do_write(17'h00000, 8'h00);
    do_write(17'h00000, 8'hFF);
    do_read(17'h00000);
    // random traffic on a small address pool
    void'($urandom(32'd2024));
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      a = ($urandom % 4 == 0) ? 17'($urandom) : {13'h0AB5, 4'($urandom)};
      if ($urandom % 2) do_write(a, 8'($urandom));
      else do_read(a);
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule